// File: doc/BRIEF.md
# Reset Exception State Initializer

This block creates the processor state that takes effect on a reset. While the reset input is low, the block holds execution stopped at once, with no clock edge needed. On the first clock edge after reset is released, it loads the status-register fields: mode, the two interrupt masks, the instruction-set state bit and endianness. In that same cycle it captures two configuration straps into the control register's vector-select and endianness bits. It then issues one start-fetch request at the reset vector that the vector strap selects.

A core front end uses the run output to gate instruction issue and takes the one-cycle fetch request as its first fetch. Every reset source in the system drives the same reset input, so the block has a single reset behaviour with no levels. Reset may be reasserted at any time, including while the core is running. Each release repeats the sequence with freshly sampled straps.

Top module: `resetStateInit`

## Requirements
- R1: While `rstN` is low, `coreRun` and `fetchValid` are 0 immediately, asynchronously, without waiting for a clock edge.
- R2: From reset and after release, `psrMode` reads binary 10011 (supervisor).
- R3: From reset and after release, `psrMaskIrq` and `psrMaskFiq` are both 1 and `psrIsaState` is 0.
- R4: The start-fetch address is 0x00000000 when the captured vector strap is 0, and 0xFFFF0000 when it is 1.
- R5: `ctlVecSel` takes the value of `cfgHighVec` as sampled on the first rising clock edge at which `rstN` is high.
- R6: `ctlEndian` and `psrEndian` both take the value of `cfgBigEnd` sampled at that same edge, and are always equal while running.
- R7: `fetchValid` is 1 for exactly one cycle, starting at the first rising edge after release. `coreRun` rises at that same edge and stays 1 until the next reset.
- R8: Changes on `cfgHighVec` or `cfgBigEnd` after the capture edge have no effect on any output until reset is asserted again.
- R9: A reset asserted mid-run returns every output to its reset value. The next release repeats the R5–R7 sequence with newly sampled straps.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low reset, asynchronous assertion; all reset sources merged |
| cfgHighVec | input | 1 | Strap: 1 selects the high reset vector |
| cfgBigEnd | input | 1 | Strap: reset value of both endianness bits |
| psrMode | output | 5 | Status register mode field |
| psrMaskIrq | output | 1 | Status register normal-interrupt mask |
| psrMaskFiq | output | 1 | Status register fast-interrupt mask |
| psrIsaState | output | 1 | Status register instruction-set state bit |
| psrEndian | output | 1 | Status register endianness bit |
| ctlVecSel | output | 1 | Control register vector-select bit |
| ctlEndian | output | 1 | Control register endianness bit |
| coreRun | output | 1 | Execution enabled |
| fetchAddr | output | 32 | Start-fetch address |
| fetchValid | output | 1 | One-cycle start-fetch request |

## Verification
The bench goes after these corner cases:
- **Halt within a cycle.** It asserts reset in the middle of a clock period while running and checks the halt before the next edge. A synchronous-only reset would leave `coreRun` high.
- **Every strap combination.** It releases reset under all four strap combinations. A swapped vector constant, or an endianness bit that is loaded into only one register, shows up as a wrong fetch address or mismatched endianness bits.
- **Straps toggling after capture.** It toggles both straps after capture. A design that samples them continuously would change the control bits.
- **Exactly one request per release.** It counts fetch requests per release. A level-held or repeated request gives a count other than one, and so does a missing re-issue after a second reset.

// File: rtl/resetInitPkg.sv
package resetInitPkg;
  // Strobes from control to datapath.
  typedef struct packed {
    logic loadState;   // capture straps and architectural reset values
    logic issueFetch;  // raise the start-fetch request
  } initStrobes_t;

  typedef enum logic [1:0] {
    ST_HELD  = 2'd0,
    ST_ISSUE = 2'd1,
    ST_RUN   = 2'd2
  } initState_t;
endpackage

// File: rtl/resetInitCtrl.sv
module resetInitCtrl
  import resetInitPkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  output initStrobes_t strobes,
  output logic         runEn
);
  initState_t stateQ, stateD;

  always_comb begin
    stateD = stateQ;
    strobes = '0;
    unique case (stateQ)
      ST_HELD: begin
        strobes.loadState  = 1'b1;
        strobes.issueFetch = 1'b1;
        stateD = ST_ISSUE;
      end
      ST_ISSUE: stateD = ST_RUN;
      ST_RUN:   stateD = ST_RUN;
      default:  stateD = ST_HELD;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stateQ <= ST_HELD;
      runEn  <= 1'b0;
    end else begin
      stateQ <= stateD;
      runEn  <= 1'b1;
    end
  end
endmodule

// File: rtl/resetInitDatapath.sv
module resetInitDatapath
  import resetInitPkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int MODE_W = 5,
  parameter logic [MODE_W-1:0] RESET_MODE = 5'b10011,
  parameter logic [ADDR_W-1:0] LOW_VEC  = 32'h0000_0000,
  parameter logic [ADDR_W-1:0] HIGH_VEC = 32'hFFFF_0000
) (
  input  logic              clk,
  input  logic              rstN,
  input  initStrobes_t      strobes,
  input  logic              cfgHighVec,
  input  logic              cfgBigEnd,
  output logic [MODE_W-1:0] modeQ,
  output logic              maskIrqQ,
  output logic              maskFiqQ,
  output logic              isaQ,
  output logic              psrEndQ,
  output logic              vecSelQ,
  output logic              ctlEndQ,
  output logic [ADDR_W-1:0] addrQ,
  output logic              validQ
);
  logic [ADDR_W-1:0] vecAddr;
  assign vecAddr = cfgHighVec ? HIGH_VEC : LOW_VEC;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      modeQ    <= RESET_MODE;
      maskIrqQ <= 1'b1;
      maskFiqQ <= 1'b1;
      isaQ     <= 1'b0;
      psrEndQ  <= 1'b0;
      vecSelQ  <= 1'b0;
      ctlEndQ  <= 1'b0;
      addrQ    <= LOW_VEC;
      validQ   <= 1'b0;
    end else begin
      validQ <= strobes.issueFetch;
      if (strobes.loadState) begin
        modeQ    <= RESET_MODE;
        maskIrqQ <= 1'b1;
        maskFiqQ <= 1'b1;
        isaQ     <= 1'b0;
        psrEndQ  <= cfgBigEnd;
        ctlEndQ  <= cfgBigEnd;
        vecSelQ  <= cfgHighVec;
        addrQ    <= vecAddr;
      end
    end
  end
endmodule

// File: rtl/resetStateInit.sv
module resetStateInit
  import resetInitPkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int MODE_W = 5,
  parameter logic [MODE_W-1:0] RESET_MODE = 5'b10011,
  parameter logic [ADDR_W-1:0] LOW_VEC  = 32'h0000_0000,
  parameter logic [ADDR_W-1:0] HIGH_VEC = 32'hFFFF_0000
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgHighVec,
  input  logic              cfgBigEnd,
  output logic [MODE_W-1:0] psrMode,
  output logic              psrMaskIrq,
  output logic              psrMaskFiq,
  output logic              psrIsaState,
  output logic              psrEndian,
  output logic              ctlVecSel,
  output logic              ctlEndian,
  output logic              coreRun,
  output logic [ADDR_W-1:0] fetchAddr,
  output logic              fetchValid
);
  initStrobes_t strobes;

  resetInitCtrl u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .strobes (strobes),
    .runEn   (coreRun)
  );

  resetInitDatapath #(
    .ADDR_W(ADDR_W), .MODE_W(MODE_W), .RESET_MODE(RESET_MODE),
    .LOW_VEC(LOW_VEC), .HIGH_VEC(HIGH_VEC)
  ) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .strobes    (strobes),
    .cfgHighVec (cfgHighVec),
    .cfgBigEnd  (cfgBigEnd),
    .modeQ      (psrMode),
    .maskIrqQ   (psrMaskIrq),
    .maskFiqQ   (psrMaskFiq),
    .isaQ       (psrIsaState),
    .psrEndQ    (psrEndian),
    .vecSelQ    (ctlVecSel),
    .ctlEndQ    (ctlEndian),
    .addrQ      (fetchAddr),
    .validQ     (fetchValid)
  );
endmodule

// File: rtl/resetStateInitChecker.sv
module resetStateInitChecker #(
  parameter int ADDR_W = 32,
  parameter int MODE_W = 5,
  parameter logic [MODE_W-1:0] RESET_MODE = 5'b10011,
  parameter logic [ADDR_W-1:0] LOW_VEC  = 32'h0000_0000,
  parameter logic [ADDR_W-1:0] HIGH_VEC = 32'hFFFF_0000
) (
  input logic              clk,
  input logic              rstN,
  input logic [MODE_W-1:0] psrMode,
  input logic              psrMaskIrq,
  input logic              psrMaskFiq,
  input logic              psrIsaState,
  input logic              psrEndian,
  input logic              ctlVecSel,
  input logic              ctlEndian,
  input logic              coreRun,
  input logic [ADDR_W-1:0] fetchAddr,
  input logic              fetchValid
);
  // R1: halted whenever reset is seen low at an edge
  always @(posedge clk) begin
    if (rstN === 1'b0) begin
      p_halt_in_reset_r1: assert (!coreRun && !fetchValid);
    end
  end

  p_mode_r2: assert property (@(posedge clk) disable iff (!rstN)
    coreRun |-> psrMode == RESET_MODE);

  p_masks_r3: assert property (@(posedge clk) disable iff (!rstN)
    coreRun |-> (psrMaskIrq && psrMaskFiq && !psrIsaState));

  p_vector_r4: assert property (@(posedge clk) disable iff (!rstN)
    fetchValid |-> fetchAddr == (ctlVecSel ? HIGH_VEC : LOW_VEC));

  p_endian_pair_r6: assert property (@(posedge clk) disable iff (!rstN)
    coreRun |-> psrEndian == ctlEndian);

  p_single_pulse_r7: assert property (@(posedge clk) disable iff (!rstN)
    fetchValid |=> !fetchValid);

  p_pulse_with_run_r7: assert property (@(posedge clk) disable iff (!rstN)
    fetchValid |-> coreRun);

  p_run_sticky_r7: assert property (@(posedge clk) disable iff (!rstN)
    coreRun |=> coreRun);

  p_straps_held_r8: assert property (@(posedge clk) disable iff (!rstN)
    (coreRun && !fetchValid) |-> ($stable(ctlVecSel) && $stable(ctlEndian) && $stable(fetchAddr)));
endmodule

bind resetStateInit resetStateInitChecker #(
  .ADDR_W(ADDR_W), .MODE_W(MODE_W), .RESET_MODE(RESET_MODE),
  .LOW_VEC(LOW_VEC), .HIGH_VEC(HIGH_VEC)
) u_chk (.*);

// File: tb/tb_resetStateInit.sv
module tb_resetStateInit;
  typedef struct {
    logic [31:0] addr;
    logic        vec;
    logic        endi;
  } expItem_t;

  logic clk = 1'b0;
  logic rstN, cfgHighVec, cfgBigEnd;
  logic [4:0]  psrMode;
  logic        psrMaskIrq, psrMaskFiq, psrIsaState, psrEndian;
  logic        ctlVecSel, ctlEndian, coreRun, fetchValid;
  logic [31:0] fetchAddr;

  int errs = 0;
  int checks = 0;
  int pulseCount = 0;
  bit done = 1'b0;
  expItem_t expQ[$];

  always #5 clk = ~clk;

  resetStateInit dut (
    .clk(clk), .rstN(rstN), .cfgHighVec(cfgHighVec), .cfgBigEnd(cfgBigEnd),
    .psrMode(psrMode), .psrMaskIrq(psrMaskIrq), .psrMaskFiq(psrMaskFiq),
    .psrIsaState(psrIsaState), .psrEndian(psrEndian), .ctlVecSel(ctlVecSel),
    .ctlEndian(ctlEndian), .coreRun(coreRun), .fetchAddr(fetchAddr),
    .fetchValid(fetchValid)
  );

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Monitor: pops an expected fetch for every request seen.
  always @(negedge clk) begin
    if (rstN === 1'b1 && fetchValid === 1'b1) begin
      pulseCount++;
      if (expQ.size() == 0) begin
        check(1'b0, "R7 unexpected fetch", 32'd1, 32'd0);
      end else begin
        expItem_t e;
        e = expQ.pop_front();
        check(fetchAddr === e.addr, "R4 fetch address", fetchAddr, e.addr);
        check(ctlVecSel === e.vec, "R5 vector select", {31'd0, ctlVecSel}, {31'd0, e.vec});
        check(ctlEndian === e.endi && psrEndian === e.endi, "R6 endianness pair",
              {30'd0, psrEndian, ctlEndian}, {30'd0, e.endi, e.endi});
        check(coreRun === 1'b1, "R7 run with fetch", {31'd0, coreRun}, 32'd1);
      end
    end
  end

  // Driver: release reset with given straps and push the expected fetch.
  task automatic releaseWith(input logic hv, input logic be);
    expItem_t e;
    e.addr = hv ? 32'hFFFF_0000 : 32'h0000_0000;
    e.vec  = hv;
    e.endi = be;
    expQ.push_back(e);
    @(posedge clk); #2;
    pulseCount = 0;
    cfgHighVec = hv;
    cfgBigEnd  = be;
    rstN = 1'b1;
    repeat (4) @(negedge clk);
    #1;
    check(pulseCount == 1, "R7 one pulse per release", pulseCount, 32'd1);
    check(fetchValid === 1'b0, "R7 pulse ended", {31'd0, fetchValid}, 32'd0);
    check(psrMode === 5'b10011, "R2 mode", {27'd0, psrMode}, 32'h13);
    check(psrMaskIrq === 1'b1 && psrMaskFiq === 1'b1 && psrIsaState === 1'b0,
          "R3 masks and isa", {29'd0, psrMaskIrq, psrMaskFiq, psrIsaState}, 32'h6);
  endtask

  // Reset mid-cycle while running; halt must not wait for a clock.
  task automatic midReset();
    @(posedge clk); #3;
    rstN = 1'b0;
    #1;
    check(coreRun === 1'b0 && fetchValid === 1'b0, "R1 immediate halt",
          {31'd0, coreRun}, 32'd0);
    check(ctlVecSel === 1'b0 && ctlEndian === 1'b0 && psrEndian === 1'b0,
          "R9 reset values restored", {29'd0, ctlVecSel, ctlEndian, psrEndian}, 32'd0);
    repeat (2) @(negedge clk);
  endtask

  initial begin
    rstN = 1'b0;
    cfgHighVec = 1'b1;
    cfgBigEnd = 1'b1;
    repeat (3) @(negedge clk);
    #1;
    check(coreRun === 1'b0 && fetchValid === 1'b0, "R1 held in reset",
          {30'd0, coreRun, fetchValid}, 32'd0);
    check(psrMode === 5'b10011, "R2 mode in reset", {27'd0, psrMode}, 32'h13);
    check(psrMaskIrq === 1'b1 && psrMaskFiq === 1'b1 && psrIsaState === 1'b0,
          "R3 masks in reset", {29'd0, psrMaskIrq, psrMaskFiq, psrIsaState}, 32'h6);
    check(pulseCount == 0, "R7 no fetch in reset", pulseCount, 32'd0);

    releaseWith(1'b0, 1'b0);
    // R8: strap changes after capture ignored
    @(posedge clk); #2;
    cfgHighVec = 1'b1;
    cfgBigEnd = 1'b1;
    repeat (3) @(negedge clk);
    #1;
    check(ctlVecSel === 1'b0 && ctlEndian === 1'b0 && psrEndian === 1'b0,
          "R8 straps ignored", {29'd0, ctlVecSel, ctlEndian, psrEndian}, 32'd0);
    check(fetchAddr === 32'h0 && pulseCount == 1, "R8 no refetch", fetchAddr, 32'h0);

    midReset();
    releaseWith(1'b1, 1'b1);
    @(posedge clk); #2;
    cfgHighVec = 1'b0;
    cfgBigEnd = 1'b0;
    repeat (3) @(negedge clk);
    #1;
    check(ctlVecSel === 1'b1 && ctlEndian === 1'b1 && psrEndian === 1'b1,
          "R8 straps ignored high", {29'd0, ctlVecSel, ctlEndian, psrEndian}, 32'h7);

    midReset();
    releaseWith(1'b1, 1'b0);
    midReset();
    releaseWith(1'b0, 1'b1);
    midReset();
    releaseWith(1'b1, 1'b1);   // R9: repeated release repeats the sequence

    check(expQ.size() == 0, "R9 all fetches seen", expQ.size(), 32'd0);
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (200000) @(posedge clk);
        check(1'b0, "watchdog", 32'd0, 32'd1);
      end
    join_any
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule